// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a bank of 32-bit chip-level control words. Bus masters reach it through a plain single-cycle register port that carries one byte address, a write strobe with write data, and a read strobe with registered read data. The words do nothing on their own. Other logic on the chip reads them, so the bank only stores, protects and returns values.

Word 0 is a protection key. While the key word holds one exact magic value, the bank is unlocked and the lower configuration window accepts writes. Any other value locks it. A fixed set of status words never takes a write. Each word's reset value comes from one slot of a flat parameter vector, so a single design can be set up for several chip variants.

Rejected accesses are dropped without side effects and signalled by a one-cycle error pulse. An access is rejected when it is:
- a locked write,
- a write to a read-only word,
- any access past the last word,
- any access with a misaligned address.

A read of the one word that is write-only by convention also raises the pulse.

Top module: `ctrl_regbank`

## Requirements
- R1: During synchronous active-high reset, word i (byte offset 4*i) loads bits [32*i+31:32*i] of the RST_VALS parameter. The key word at offset 0x000 is the exception and always resets to zero, so the bank starts locked. rd_data and err reset to zero.
- R2: A read of an aligned, in-range offset returns the stored word on rd_data one clock after rd_en. rd_data holds its value while rd_en is low. A read and a write of the same offset in one cycle return the old value.
- R3: The key word at offset 0x000 is always writable. The bank is unlocked exactly while that word equals 0x1688A8A8, and writing any other value to it locks the bank.
- R4: While locked, a write to any offset from 0x004 to 0x100 inclusive is dropped and produces an err pulse. Offsets from 0x104 to 0x1A4 accept writes whether locked or not.
- R5: These offsets are read-only at all times, and writes to them are dropped with an err pulse:
  - 0x014
  - 0x050 to 0x06C
  - 0x078
  - 0x07C
  - 0x0E0
  - 0x0E4

  Reads of these offsets return their reset values.
- R6: The bank holds 106 words. A read at a byte address of 0x1A8 or above returns zero with an err pulse. A write there changes no word and produces an err pulse.
- R7: An access whose address has a nonzero value in bits [1:0] has no effect and produces an err pulse. A misaligned read returns zero.
- R8: Offset 0x0C0 is write-only by convention. It takes writes like any other word in the window, but a read of it returns the stored value and also produces an err pulse.
- R9: err is high for exactly the one cycle after an offending request. It stays low after accepted accesses and after idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (12) | Byte address shared by read and write |
| wr_en | input | 1 | Write request this cycle |
| wr_data | input | DATA_W (32) | Write data, little-endian word |
| rd_en | input | 1 | Read request this cycle |
| rd_data | output | DATA_W (32) | Registered read data, valid the cycle after rd_en |
| err | output | 1 | One-cycle pulse for a rejected access |

## Verification
The assertions take three things for granted:
- reset is held from the first clock edge,
- addr, wr_data and the strobes are known and steady around each rising edge,
- at most one request (a read, a write, or a read and write to the same address) is issued per cycle.

The stimulus changes inputs only on the falling edge, and it drops both strobes after each request so that every error pulse can be traced to one access. Sweeps cover every aligned word, both locked and unlocked. They also cover every misaligned byte address in range and every out-of-range word address.

// File: rtl/ctrl_regbank_pkg.sv
package ctrl_regbank_pkg;

    localparam int WORD_BYTES = 4;
    localparam int IDX_MAX_W  = 10;

    // Key value that opens the protected window
    localparam logic [31:0] UNLOCK_MAGIC = 32'h1688_A8A8;

    localparam int KEY_IDX      = 0;
    localparam int GUARD_LO_IDX = 1;   // byte 0x004
    localparam int GUARD_HI_IDX = 64;  // byte 0x100
    localparam int WONLY_IDX    = 48;  // byte 0x0C0

    typedef logic [IDX_MAX_W-1:0] word_idx_t;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_GRANT,
        ACC_LOCKED,
        ACC_READONLY,
        ACC_RANGE,
        ACC_ALIGN,
        ACC_WONLY
    } verdict_e;

    typedef struct packed {
        word_idx_t idx;
        logic      aligned;
        logic      in_range;
        logic      guarded;
        logic      readonly;
        logic      writeonly;
    } addr_info_t;

    typedef struct packed {
        logic wr_go;
        logic rd_go;
        logic fault;
    } grant_t;

    function automatic logic idx_readonly(input int unsigned i);
        return (i == 5) || (i >= 20 && i <= 27) || (i == 30) || (i == 31) ||
               (i == 56) || (i == 57);
    endfunction

    function automatic logic idx_guarded(input int unsigned i);
        return (i >= GUARD_LO_IDX) && (i <= GUARD_HI_IDX);
    endfunction

endpackage

// File: rtl/crb_decode.sv
module crb_decode
    import ctrl_regbank_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 106
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_info_t        info
);

    logic [31:0] word32;

    always_comb begin
        word32        = 32'(addr[ADDR_W-1:2]);
        info          = '0;
        info.idx      = word_idx_t'(word32);
        info.aligned  = (addr[1:0] == 2'b00);
        info.in_range = (word32 < 32'(NUM_WORDS));
        if (info.in_range) begin
            info.guarded   = idx_guarded(word32);
            info.readonly  = idx_readonly(word32);
            info.writeonly = (word32 == 32'(WONLY_IDX));
        end
    end

endmodule

// File: rtl/crb_guard.sv
module crb_guard
    import ctrl_regbank_pkg::*;
(
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       unlocked,
    input  addr_info_t info,
    output grant_t     grant
);

    verdict_e wr_v;
    verdict_e rd_v;

    // Write verdict, in priority order
    always_comb begin
        wr_v = ACC_IDLE;
        if (wr_en) begin
            if (!info.aligned)                    wr_v = ACC_ALIGN;
            else if (!info.in_range)              wr_v = ACC_RANGE;
            else if (info.readonly)               wr_v = ACC_READONLY;
            else if (info.guarded && !unlocked)   wr_v = ACC_LOCKED;
            else                                  wr_v = ACC_GRANT;
        end
    end

    // Read verdict; the write-only word still returns data
    always_comb begin
        rd_v = ACC_IDLE;
        if (rd_en) begin
            if (!info.aligned)       rd_v = ACC_ALIGN;
            else if (!info.in_range) rd_v = ACC_RANGE;
            else if (info.writeonly) rd_v = ACC_WONLY;
            else                     rd_v = ACC_GRANT;
        end
    end

    always_comb begin
        grant.wr_go = (wr_v == ACC_GRANT);
        grant.rd_go = (rd_v == ACC_GRANT) || (rd_v == ACC_WONLY);
        grant.fault = (wr_en && wr_v != ACC_GRANT) || (rd_en && rd_v != ACC_GRANT);
    end

endmodule

// File: rtl/crb_store.sv
module crb_store
    import ctrl_regbank_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 106,
    parameter logic [NUM_WORDS*DATA_W-1:0] RST_FLAT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  word_idx_t         idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_word,
    output logic              unlocked
);

    logic [NUM_WORDS*DATA_W-1:0] bank_flat;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        if (idx_readonly(g)) begin : g_ro
            // Status word: fixed at its reset value, no storage
            assign bank_flat[g*DATA_W +: DATA_W] = RST_FLAT[g*DATA_W +: DATA_W];
        end else begin : g_rw
            localparam logic [DATA_W-1:0] INIT_V =
                (g == KEY_IDX) ? '0 : RST_FLAT[g*DATA_W +: DATA_W];
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= INIT_V;
                else if (wr_go && idx == word_idx_t'(g))
                    q <= wr_data;
            end
            assign bank_flat[g*DATA_W +: DATA_W] = q;
        end
    end

    assign unlocked = (bank_flat[KEY_IDX*DATA_W +: DATA_W] == DATA_W'(UNLOCK_MAGIC));

    always_comb begin
        rd_word = '0;
        if (32'(idx) < 32'(NUM_WORDS))
            rd_word = bank_flat[32'(idx)*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/ctrl_regbank.sv
module ctrl_regbank
    import ctrl_regbank_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 106,
    parameter logic [NUM_WORDS*DATA_W-1:0] RST_VALS = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              err
);

    addr_info_t        info;
    grant_t            grant;
    logic              unlocked;
    logic [DATA_W-1:0] rd_word;

    crb_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(NUM_WORDS)
    ) u_decode (
        .addr(addr),
        .info(info)
    );

    crb_guard u_guard (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .unlocked(unlocked),
        .info    (info),
        .grant   (grant)
    );

    crb_store #(
        .DATA_W   (DATA_W),
        .NUM_WORDS(NUM_WORDS),
        .RST_FLAT (RST_VALS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_go   (grant.wr_go),
        .idx     (info.idx),
        .wr_data (wr_data),
        .rd_word (rd_word),
        .unlocked(unlocked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            err     <= 1'b0;
        end else begin
            err <= grant.fault;
            if (rd_en)
                rd_data <= grant.rd_go ? rd_word : '0;
        end
    end

endmodule

// File: rtl/ctrl_regbank_chk.sv
module ctrl_regbank_chk
    import ctrl_regbank_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 106
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              err,
    input logic              unlocked
);

    localparam logic [ADDR_W-1:0] LIMIT  = ADDR_W'(NUM_WORDS * WORD_BYTES);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(GUARD_LO_IDX * WORD_BYTES);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(GUARD_HI_IDX * WORD_BYTES);
    localparam logic [ADDR_W-1:0] WO_ADR = ADDR_W'(WONLY_IDX * WORD_BYTES);

    p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    p_magic_unlocks_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == '0 && wr_data == DATA_W'(UNLOCK_MAGIC)) |=> unlocked);

    p_other_key_locks_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == '0 && wr_data != DATA_W'(UNLOCK_MAGIC)) |=> !unlocked);

    p_locked_window_err_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !unlocked && addr[1:0] == 2'b00 && addr >= WIN_LO && addr <= WIN_HI)
        |=> err);

    p_readonly_err_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[1:0] == 2'b00 && addr < LIMIT &&
         idx_readonly(32'(addr[ADDR_W-1:2]))) |=> err);

    p_range_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr >= LIMIT) |=> (err && rd_data == '0));

    p_misaligned_read_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[1:0] != 2'b00) |=> (err && rd_data == '0));

    p_wonly_read_err_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == WO_ADR) |=> err);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !wr_en) |=> !err);

endmodule

bind ctrl_regbank ctrl_regbank_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_WORDS(NUM_WORDS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .err     (err),
    .unlocked(unlocked)
);

// File: tb/ctrl_regbank_test.sv
`timescale 1ns/1ps
module ctrl_regbank_test;

    localparam int NW = 106;
    localparam logic [31:0] MAGIC = 32'h1688_A8A8;

    function automatic logic [31:0] rv(input int i);
        return 32'hC0DE_0000 ^ (32'(i) * 32'h0001_0F1D);
    endfunction

    function automatic logic [NW*32-1:0] build_img();
        logic [NW*32-1:0] img;
        img = '0;
        for (int i = 0; i < NW; i++)
            img[i*32 +: 32] = (i == 0) ? MAGIC : rv(i);
        return img;
    endfunction

    localparam logic [NW*32-1:0] RST_IMG = build_img();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        err;

    always #10 clk = ~clk;

    ctrl_regbank #(
        .ADDR_W(12), .DATA_W(32), .NUM_WORDS(NW), .RST_VALS(RST_IMG)
    ) uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .err(err)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mdl [NW];
    logic locked_m;
    logic [31:0] got_rd;
    logic got_err;

    function automatic logic is_ro(input int i);
        return i == 5 || (i >= 20 && i <= 27) || i == 30 || i == 31 || i == 56 || i == 57;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic r, input logic w, input int a, input logic [31:0] d);
        @(negedge clk);
        addr = 12'(a); rd_en = r; wr_en = w; wr_data = d;
        @(negedge clk);
        got_rd = rd_data; got_err = err;
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic do_wr(input int a, input logic [31:0] d, input string req);
        int i;
        logic e;
        i = a >> 2;
        e = 1'b0;
        if ((a % 4) != 0)                             e = 1'b1;
        else if (i >= NW)                             e = 1'b1;
        else if (is_ro(i))                            e = 1'b1;
        else if (i >= 1 && i <= 64 && locked_m)       e = 1'b1;
        else begin
            mdl[i] = d;
            if (i == 0) locked_m = (d != MAGIC);
        end
        access(1'b0, 1'b1, a, d);
        chk(32'(got_err), 32'(e), req);
    endtask

    task automatic do_rd(input int a, input string req);
        int i;
        logic [31:0] x;
        logic e;
        i = a >> 2;
        if ((a % 4) != 0 || i >= NW) begin x = '0; e = 1'b1; end
        else begin x = mdl[i]; e = (i == 48); end
        access(1'b1, 1'b0, a, '0);
        chk(got_rd, x, req);
        chk(32'(got_err), 32'(e), req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) mdl[i] = is_ro(i) ? rv(i) : ((i == 0) ? 32'h0 : rv(i));
        locked_m = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_data, 32'h0, "R1 rd_data reset");
        chk(32'(err), 32'h0, "R1 err reset");

        // R1 / R8: reset image, key forced to zero, 0xC0 read flags err
        for (int i = 0; i < NW; i++) do_rd(i*4, "R1 reset value sweep");

        // R4 / R5: locked write sweep then readback
        for (int i = 1; i < NW; i++) do_wr(i*4, ~rv(i), "R4 locked write sweep");
        for (int i = 0; i < NW; i++) do_rd(i*4, "R4 locked readback");

        // R3: near-miss key keeps lock, magic opens
        do_wr(0, MAGIC ^ 32'h1, "R3 bad key write");
        do_wr(8, 32'h1234_5678, "R3 window still locked");
        do_rd(8, "R3 window unchanged");
        do_wr(0, MAGIC, "R3 magic key write");
        do_rd(0, "R3 key readback");

        // R4 / R5 / R8: unlocked write sweep then readback
        for (int i = 1; i < NW; i++) do_wr(i*4, 32'(i) * 32'h9E37_79B1, "R4 unlocked write sweep");
        for (int i = 0; i < NW; i++) do_rd(i*4, "R5 unlocked readback");

        // R2: simultaneous read and write returns old value
        for (int k = 0; k < 3; k++) begin
            int a;
            logic [31:0] old;
            a = (k == 0) ? 12'h080 : ((k == 1) ? 12'h120 : 12'h19C);
            old = mdl[a >> 2];
            mdl[a >> 2] = 32'hA5A5_0000 | 32'(k);
            access(1'b1, 1'b1, a, mdl[a >> 2]);
            chk(got_rd, old, "R2 read-during-write old value");
            chk(32'(got_err), 32'h0, "R9 no err on accepted access");
            do_rd(a, "R2 new value after write");
        end

        // R2 / R9: rd_data holds and err stays low when idle
        do_rd(12'h040, "R2 read before idle");
        access(1'b0, 1'b0, 0, '0);
        chk(got_rd, mdl[16], "R2 rd_data holds while idle");
        chk(32'(got_err), 32'h0, "R9 idle no err");

        // R7: every misaligned byte in range, unlocked
        for (int i = 0; i < NW; i++)
            for (int o = 1; o < 4; o++) do_wr(i*4 + o, 32'hDEAD_BEEF, "R7 misaligned write");
        for (int i = 0; i < NW; i += 7) do_rd(i*4 + 2, "R7 misaligned read");
        for (int i = 0; i < NW; i++) do_rd(i*4, "R7 no change after misaligned");

        // R6: every out-of-range word address
        for (int a = 12'h1A8; a <= 12'hFFC; a += 4) begin
            do_wr(a, 32'hFFFF_FFFF, "R6 out-of-range write");
            do_rd(a, "R6 out-of-range read");
        end
        for (int i = 0; i < NW; i++) do_rd(i*4, "R6 no change after out-of-range");

        // R3: writing another key value relocks
        do_wr(0, 32'h0, "R3 relock write");
        do_wr(12'h0C0, 32'h7777_0000, "R3 window locked again");
        do_rd(12'h0C0, "R8 write-only read after relock");
        do_wr(12'h104, 32'h0BAD_F00D, "R4 0x104 open while locked");
        do_rd(12'h104, "R4 0x104 readback");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule